// File: doc/BRIEF.md
# Multibit Trie Route Lookup Engine

The engine resolves the longest matching route prefix for a 32-bit IPv4 destination address. The route table is a multibit trie held in an on-block node memory. Each node covers three address bits. A node word packs four fields: a 7-bit bitmap of the prefixes that end inside the node, an 8-bit bitmap of the children that exist, a child base pointer and a result base pointer. Child and result addresses are not stored one by one. Each is found by adding a base pointer to the number of set bitmap bits below the selected bit.

Several lookups run at the same time in independent contexts and share one node-memory read port. The read port has a two-cycle latency, and while one context waits for its node the other contexts issue their own reads. Requests arrive on a valid/ready channel with an address and a tag. A finished lookup raises a single-cycle response carrying its tag, a next-hop index and a no-route flag. Responses may come back out of request order.

A separate node write port loads the table. It can write in any cycle and never stalls lookups.

Top module: `trie_lpm_engine`

## Requirements
- R1: A node word is {child_base[NODE_AW-1:0], res_base[RES_W-1:0], ext_bm[7:0], int_bm[6:0]}, with int_bm at the least significant end. Every walk starts at node address ROOT_ADDR (default 0). A word written through the write port is used by lookups accepted after the write cycle.
- R2: The address is consumed most significant bits first, three bits per level. Level k reads bits 31-3k down to 29-3k. At the last level (k=10) the two remaining bits, bits 1 and 0, are followed by one zero pad bit.
- R3: Bits of int_bm are assigned as follows: bit 0 is the empty prefix, bits 1 and 2 are the one-bit prefixes 0 and 1, and bits 3 to 6 are the two-bit prefixes 00, 01, 10 and 11. In a node, the longest set prefix that matches the stride bits is the hit. Its next-hop index is res_base plus the number of set int_bm bits below it.
- R4: The walk descends when ext_bm bit s is set, where s is the 3-bit stride value. The child is then at child_base plus the number of set ext_bm bits below bit s.
- R5: A hit in a deeper node replaces an earlier hit. A deeper node with no hit keeps the earlier one.
- R6: A walk that ends without any hit returns resp_miss_o=1 and resp_nh_o=0.
- R7: A walk reads at most 11 nodes. At level 10 the walk never descends, whatever ext_bm holds.
- R8: req_ready_o is high exactly when at least one of the NCTX contexts is free. NCTX lookups can be outstanding at once.
- R9: With no contention for the read port, the response comes 1+3*d cycles after the accept cycle, where d is the number of nodes read. No response ever comes less than 4 cycles after its accept.
- R10: Responses may complete out of order, and each carries its request's tag. The caller keeps the tags of outstanding lookups distinct.
- R11: A node write in any cycle does not change req_ready_o and does not delay or alter lookups that do not read the written node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | A context is free; request accepted when valid is also high |
| req_addr_i | input | ADDR_W | Destination address |
| req_tag_i | input | TAG_W | Caller tag |
| wr_en_i | input | 1 | Node write enable |
| wr_addr_i | input | NODE_AW | Node write address |
| wr_data_i | input | NODE_W | Node word, layout per R1 |
| resp_valid_o | output | 1 | Single-cycle response strobe |
| resp_tag_o | output | TAG_W | Tag of the finished lookup |
| resp_nh_o | output | RES_W | Next-hop index |
| resp_miss_o | output | 1 | No prefix matched |

## Verification
The bench builds the engine with NCTX=4 and keeps the default 32-bit address, 4-bit tag, 8-bit node pointer and 8-bit result index. Four contexts are enough to fill every context with four back-to-back 11-level walks, which makes the ready-low condition easy to observe. The same setup lets a one-level walk overtake an 11-level walk and exercises the final-level stop. A self-referencing node lets an 11-level walk use only a handful of table entries.

// File: rtl/trie_pkg.sv
package trie_pkg;
  localparam int STRIDE = 3;
  localparam int INT_W  = (1 << STRIDE) - 1;
  localparam int EXT_W  = 1 << STRIDE;
endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
  parameter int NODE_W  = 31,
  parameter int NODE_AW = 8
) (
  input  logic               clk_i,
  input  logic               wr_en_i,
  input  logic [NODE_AW-1:0] wr_addr_i,
  input  logic [NODE_W-1:0]  wr_data_i,
  input  logic [NODE_AW-1:0] rd_addr_i,
  output logic [NODE_W-1:0]  rd_data_o
);
  localparam int DEPTH = 1 << NODE_AW;

  logic [NODE_W-1:0] mem [DEPTH];
  logic [NODE_W-1:0] rd_q1, rd_q2;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
    rd_q1 <= mem[rd_addr_i];
    rd_q2 <= rd_q1;
  end

  assign rd_data_o = rd_q2;
endmodule

// File: rtl/trie_node_eval.sv
module trie_node_eval
  import trie_pkg::*;
#(
  parameter int PTR_W    = 8,
  parameter int RES_W    = 8,
  parameter int LAST_LEN = 2,
  localparam int NODE_W  = PTR_W + RES_W + EXT_W + INT_W
) (
  input  logic [NODE_W-1:0] node_i,
  input  logic [STRIDE-1:0] sbits_i,
  input  logic              last_i,
  output logic              hit_o,
  output logic [RES_W-1:0]  nh_o,
  output logic              desc_o,
  output logic [PTR_W-1:0]  child_o
);
  localparam int IW = $clog2(INT_W);

  logic [INT_W-1:0] int_bm, int_mask;
  logic [EXT_W-1:0] ext_bm, ext_mask;
  logic [RES_W-1:0] res_base;
  logic [PTR_W-1:0] child_base;
  logic [IW-1:0]    p, pos;

  assign int_bm     = node_i[INT_W-1:0];
  assign ext_bm     = node_i[INT_W +: EXT_W];
  assign res_base   = node_i[INT_W+EXT_W +: RES_W];
  assign child_base = node_i[INT_W+EXT_W+RES_W +: PTR_W];

  // longest prefix wins: lengths scanned shortest first
  always_comb begin
    hit_o = 1'b0;
    pos   = '0;
    p     = '0;
    for (int l = 0; l < STRIDE; l++) begin
      p = IW'((1 << l) - 1) + IW'(sbits_i >> (STRIDE - l));
      if (int_bm[p] && (!last_i || l <= LAST_LEN)) begin
        hit_o = 1'b1;
        pos   = p;
      end
    end
    for (int i = 0; i < INT_W; i++) int_mask[i] = (IW'(i) < pos);
    for (int i = 0; i < EXT_W; i++) ext_mask[i] = (STRIDE'(i) < sbits_i);
  end

  assign nh_o    = res_base + RES_W'($countones(int_bm & int_mask));
  assign child_o = child_base + PTR_W'($countones(ext_bm & ext_mask));
  assign desc_o  = ext_bm[sbits_i] && !last_i;
endmodule

// File: rtl/trie_rr_arb.sv
module trie_rr_arb #(
  parameter int N  = 8,
  localparam int CW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          gnt_vld_o,
  output logic [CW-1:0] gnt_idx_o
);
  logic [CW-1:0] last_q;
  int j;

  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    j = 0;
    for (int i = 0; i < N; i++) begin
      j = int'(last_q) + 1 + i;
      if (j >= N) j = j - N;
      if (!gnt_vld_o && req_i[j]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = CW'(j);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        last_q <= CW'(N - 1);
    else if (gnt_vld_o) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/trie_lpm_engine.sv
module trie_lpm_engine
  import trie_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 4,
  parameter int NCTX      = 8,
  parameter int NODE_AW   = 8,
  parameter int RES_W     = 8,
  parameter int ROOT_ADDR = 0,
  localparam int NODE_W   = NODE_AW + RES_W + EXT_W + INT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [TAG_W-1:0]   req_tag_i,
  input  logic               wr_en_i,
  input  logic [NODE_AW-1:0] wr_addr_i,
  input  logic [NODE_W-1:0]  wr_data_i,
  output logic               resp_valid_o,
  output logic [TAG_W-1:0]   resp_tag_o,
  output logic [RES_W-1:0]   resp_nh_o,
  output logic               resp_miss_o
);
  localparam int CW       = $clog2(NCTX);
  localparam int LEVELS   = (ADDR_W + STRIDE - 1) / STRIDE;
  localparam int LW       = $clog2(LEVELS);
  localparam int LAST_LEN = ADDR_W - (LEVELS - 1) * STRIDE;

  logic [NCTX-1:0]    busy_q, pend_q, bvld_q;
  logic [ADDR_W-1:0]  addr_q [NCTX];
  logic [LW-1:0]      lvl_q  [NCTX];
  logic [NODE_AW-1:0] node_q [NCTX];
  logic [TAG_W-1:0]   tag_q  [NCTX];
  logic [RES_W-1:0]   bnh_q  [NCTX];

  logic          free_vld, acc, gnt_vld;
  logic [CW-1:0] free_idx, gnt_idx;
  logic          p1_vld, p2_vld;
  logic [CW-1:0] p1_ctx, p2_ctx;

  logic [NODE_W-1:0]  rd_data;
  logic               e_hit, e_desc, e_last;
  logic [RES_W-1:0]   e_nh;
  logic [NODE_AW-1:0] e_child;

  always_comb begin
    free_vld = 1'b0;
    free_idx = '0;
    for (int i = NCTX - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        free_vld = 1'b1;
        free_idx = CW'(i);
      end
    end
  end

  assign req_ready_o = free_vld;
  assign acc         = req_valid_i && free_vld;

  trie_rr_arb #(.N(NCTX)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (pend_q),
    .gnt_vld_o (gnt_vld),
    .gnt_idx_o (gnt_idx)
  );

  trie_node_mem #(.NODE_W(NODE_W), .NODE_AW(NODE_AW)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (node_q[gnt_idx]),
    .rd_data_o (rd_data)
  );

  assign e_last = (lvl_q[p2_ctx] == LW'(LEVELS - 1));

  trie_node_eval #(.PTR_W(NODE_AW), .RES_W(RES_W), .LAST_LEN(LAST_LEN)) u_eval (
    .node_i  (rd_data),
    .sbits_i (addr_q[p2_ctx][ADDR_W-1 -: STRIDE]),
    .last_i  (e_last),
    .hit_o   (e_hit),
    .nh_o    (e_nh),
    .desc_o  (e_desc),
    .child_o (e_child)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q       <= '0;
      pend_q       <= '0;
      bvld_q       <= '0;
      p1_vld       <= 1'b0;
      p2_vld       <= 1'b0;
      p1_ctx       <= '0;
      p2_ctx       <= '0;
      resp_valid_o <= 1'b0;
      resp_tag_o   <= '0;
      resp_nh_o    <= '0;
      resp_miss_o  <= 1'b0;
      for (int i = 0; i < NCTX; i++) begin
        addr_q[i] <= '0;
        lvl_q[i]  <= '0;
        node_q[i] <= '0;
        tag_q[i]  <= '0;
        bnh_q[i]  <= '0;
      end
    end else begin
      p1_vld       <= gnt_vld;
      p1_ctx       <= gnt_idx;
      p2_vld       <= p1_vld;
      p2_ctx       <= p1_ctx;
      resp_valid_o <= 1'b0;
      if (gnt_vld) pend_q[gnt_idx] <= 1'b0;
      if (p2_vld) begin
        if (e_hit) begin
          bvld_q[p2_ctx] <= 1'b1;
          bnh_q[p2_ctx]  <= e_nh;
        end
        if (e_desc) begin
          pend_q[p2_ctx] <= 1'b1;
          node_q[p2_ctx] <= e_child;
          lvl_q[p2_ctx]  <= lvl_q[p2_ctx] + LW'(1);
          addr_q[p2_ctx] <= addr_q[p2_ctx] << STRIDE;
        end else begin
          busy_q[p2_ctx] <= 1'b0;
          resp_valid_o   <= 1'b1;
          resp_tag_o     <= tag_q[p2_ctx];
          resp_miss_o    <= !(e_hit || bvld_q[p2_ctx]);
          resp_nh_o      <= e_hit ? e_nh : (bvld_q[p2_ctx] ? bnh_q[p2_ctx] : '0);
        end
      end
      if (acc) begin
        busy_q[free_idx] <= 1'b1;
        pend_q[free_idx] <= 1'b1;
        bvld_q[free_idx] <= 1'b0;
        node_q[free_idx] <= NODE_AW'(ROOT_ADDR);
        lvl_q[free_idx]  <= '0;
        addr_q[free_idx] <= req_addr_i;
        tag_q[free_idx]  <= req_tag_i;
      end
    end
  end
endmodule

// File: rtl/trie_lpm_chk.sv
module trie_lpm_chk #(
  parameter int TAG_W = 4,
  parameter int NCTX  = 8,
  parameter int RES_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [TAG_W-1:0] req_tag_i,
  input logic             resp_valid_o,
  input logic [TAG_W-1:0] resp_tag_o,
  input logic [RES_W-1:0] resp_nh_o,
  input logic             resp_miss_o
);
  localparam int OW   = $clog2(NCTX + 1) + 1;
  localparam int NTAG = 1 << TAG_W;

  logic          acc;
  logic [OW-1:0] occ_q, occ_now;
  logic [OW-1:0] tcnt_q [NTAG];

  assign acc     = req_valid_i && req_ready_o;
  assign occ_now = occ_q - OW'(resp_valid_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q <= '0;
      for (int t = 0; t < NTAG; t++) tcnt_q[t] <= '0;
    end else begin
      occ_q <= occ_q + OW'(acc) - OW'(resp_valid_o);
      for (int t = 0; t < NTAG; t++)
        tcnt_q[t] <= tcnt_q[t] + OW'(acc && req_tag_i == TAG_W'(t))
                               - OW'(resp_valid_o && resp_tag_o == TAG_W'(t));
    end
  end

  // R8
  ready_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == (occ_now < OW'(NCTX)));

  // R10
  tag_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> tcnt_q[resp_tag_o] != '0);

  // R6
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_miss_o) |-> resp_nh_o == '0);

  // R9
  min_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !(($past(acc, 1) && $past(req_tag_i, 1) == resp_tag_o) ||
                       ($past(acc, 2) && $past(req_tag_i, 2) == resp_tag_o) ||
                       ($past(acc, 3) && $past(req_tag_i, 3) == resp_tag_o)));
endmodule

bind trie_lpm_engine trie_lpm_chk #(.TAG_W(TAG_W), .NCTX(NCTX), .RES_W(RES_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_tag_i    (req_tag_i),
  .resp_valid_o (resp_valid_o),
  .resp_tag_o   (resp_tag_o),
  .resp_nh_o    (resp_nh_o),
  .resp_miss_o  (resp_miss_o)
);

// File: tb/tb_trie_lpm_engine.sv
module tb_trie_lpm_engine;
  localparam int NCTX   = 4;
  localparam int TAG_W  = 4;
  localparam int AW     = 8;
  localparam int RW     = 8;
  localparam int NODE_W = AW + RW + 8 + 7;

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic [RW-1:0]    nh;
    logic             miss;
    int               due;
    string            rq;
  } exp_t;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              req_valid = 1'b0, req_ready;
  logic [31:0]       req_addr = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [NODE_W-1:0] wr_data = '0;
  logic              resp_valid, resp_miss;
  logic [TAG_W-1:0]  resp_tag;
  logic [RW-1:0]     resp_nh;

  int   checks = 0, fails = 0, cyc = 0;
  exp_t sb[$];
  int   resp_cyc [16];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  trie_lpm_engine #(.TAG_W(TAG_W), .NCTX(NCTX), .NODE_AW(AW), .RES_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_tag_i(req_tag),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .resp_valid_o(resp_valid), .resp_tag_o(resp_tag),
    .resp_nh_o(resp_nh), .resp_miss_o(resp_miss)
  );

  function automatic logic [NODE_W-1:0] mk(int cb, int rb, int ext, int ib);
    return {AW'(cb), RW'(rb), 8'(ext), 7'(ib)};
  endfunction

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [NODE_W-1:0] w);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = w;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // caller sits just after a posedge; leaves req_valid high
  task automatic lookup(logic [31:0] a, int tag, int nh, bit miss, int depth, bit chk_lat, string rq);
    exp_t e;
    req_valid = 1'b1; req_addr = a; req_tag = TAG_W'(tag);
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    e.tag = TAG_W'(tag); e.nh = RW'(nh); e.miss = miss; e.rq = rq;
    e.due = chk_lat ? cyc + 1 + 3 * depth : -1;
    sb.push_back(e);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    req_valid = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      int idx;
      idx = -1;
      resp_cyc[resp_tag] = cyc;
      for (int i = 0; i < sb.size(); i++) if (sb[i].tag == resp_tag) idx = i;
      if (idx < 0) check(1'b0, "R10", "unexpected tag", int'(resp_tag), -1);
      else begin
        check(resp_nh == sb[idx].nh, sb[idx].rq, "next hop", int'(resp_nh), int'(sb[idx].nh));
        check(resp_miss == sb[idx].miss, sb[idx].rq, "miss", int'(resp_miss), int'(sb[idx].miss));
        if (sb[idx].due >= 0)
          check(cyc == sb[idx].due, {sb[idx].rq, " R9"}, "latency cycle", cyc, sb[idx].due);
        sb.delete(idx);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R8", "ready after reset", int'(req_ready), 1);
    check(resp_valid == 1'b0, "R9", "no response after reset", int'(resp_valid), 0);
    @(posedge clk); #1;

    // table (R1 layout)
    wr(0, mk(1, 10, 8'h61, 7'h04));
    wr(1, mk(5, 20, 8'h08, 7'h10));
    wr(2, mk(0, 0, 0, 0));
    wr(3, mk(3, 40, 8'hFF, 7'h01));
    wr(5, mk(0, 30, 0, 7'h41));

    lookup(32'h4000_0000, 1, 0, 1, 1, 1, "R6");   drain();
    lookup(32'hE000_0000, 2, 10, 0, 1, 1, "R3");  drain();
    lookup(32'hA000_0000, 3, 10, 0, 2, 1, "R5");  drain();
    lookup(32'h0800_0000, 4, 20, 0, 2, 1, "R4");  drain();
    lookup(32'h0F00_0000, 5, 31, 0, 3, 1, "R2");  drain();
    lookup(32'h0C00_0000, 6, 30, 0, 3, 1, "R3");  drain();
    lookup(32'hC000_0000, 7, 40, 0, 11, 1, "R7"); drain();

    // R1: rewritten node takes effect
    wr(2, mk(0, 50, 0, 7'h01));
    lookup(32'hA000_0000, 3, 50, 0, 2, 1, "R1 R5"); drain();

    // R10 R11: short walk overtakes deep walk while node writes run every cycle
    fork
      begin
        wr_en = 1'b1; wr_addr = 8'd200;
        repeat (40) begin wr_data = wr_data + 1'b1; @(posedge clk); #1; end
        wr_en = 1'b0;
      end
    join_none
    lookup(32'hC000_0000, 8, 40, 0, 11, 1, "R10 R11");
    lookup(32'hE000_0000, 9, 10, 0, 1, 1, "R10 R11");
    drain();
    check(resp_cyc[9] < resp_cyc[8], "R10", "short walk returns first (cycle)", resp_cyc[9], resp_cyc[8]);
    repeat (40) @(posedge clk); #1;

    // R8: fill all contexts
    lookup(32'hC000_0000, 10, 40, 0, 11, 0, "R8");
    lookup(32'hC000_0000, 11, 40, 0, 11, 0, "R8");
    lookup(32'hC000_0000, 12, 40, 0, 11, 0, "R8");
    lookup(32'hC000_0000, 13, 40, 0, 11, 0, "R8");
    req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R8", "ready with all contexts busy", int'(req_ready), 0);
    @(posedge clk); #1;
    lookup(32'h0F00_0000, 14, 31, 0, 3, 0, "R8");
    lookup(32'h4000_0000, 15, 0, 1, 1, 0, "R8 R6");
    drain();
    check(sb.size() == 0, "R10", "all requests answered", sb.size(), 0);

    summary();
  end
endmodule